// File: doc/BRIEF.md
# Register-Mapped NAND Flash Bridge

This block lets a processor run a raw 8-bit NAND flash device through one 32-bit register. Each processor write carries three fields. An opcode picks the kind of flash cycle, one bit asks for chip enable, and one byte is the payload. The bridge turns each write into at most one flash cycle: a command latch, an address latch or a data write. The write-enable low time and the hold time that follows are set by parameters.

A write with the read-arm opcode puts the bridge in read mode. From then on, every processor read of the data port produces one read-enable strobe and returns the sampled byte. A read of the status port returns the synchronized ready/busy state of the flash.

The bus side uses a request/acknowledge handshake. The requester holds `bus_req` until it sees a one-cycle `bus_ack`. The acknowledge comes only when the whole flash cycle has finished, including its hold time.

Top module: `nand_bridge`

## Requirements
- R1: Bits 30:28 of a written word select the cycle. Value 0 gives a command cycle with `fl_cle` high and `fl_ale` low. Value 1 gives an address cycle with `fl_ale` high and `fl_cle` low. Value 3 gives a data-write cycle with both low. Value 2 sets read mode and starts no flash cycle.
- R2: Bit 31 of each accepted write sets the chip-enable request. `fl_ce_n` is the inverse of that bit and keeps its value until the next accepted write.
- R3: In a command, address or data-write cycle, `fl_io_out` carries bits 23:16 of the written word. Each such write produces exactly one write-enable pulse, so N writes give N pulses carrying their N bytes in order.
- R4: `fl_we_n` stays low for exactly WE_LOW clocks. After it rises, `fl_io_oe`, `fl_io_out`, `fl_cle` and `fl_ale` stay unchanged for exactly HOLD clocks. `fl_io_oe` is low at all other times.
- R5: In read mode, each read at bus address 0 drives `fl_re_n` low for exactly RE_LOW clocks. It returns the value `fl_io_in` had in the last low clock, in `bus_rdata[23:16]`. Any number of such reads may follow one arm write.
- R6: Every read returns the busy state in `bus_rdata[15]`, where 1 means busy. This is `fl_rb_n` inverted after a two-flop synchronizer, so it follows a pin change within four clocks. A read at bus address 1 is a status read: it makes no strobe and returns zero in bits 23:16.
- R7: Opcodes 4 to 7 make no flash cycle and leave read mode unchanged. Bit 31 still updates the chip-enable request.
- R8: `bus_ack` rises only after the flash cycle has finished. A write cycle is acknowledged WE_LOW+HOLD clocks after it is accepted. Write-enable and read-enable are never low together.
- R9: Reset deasserts every flash control: `fl_ce_n`=1, `fl_cle`=0, `fl_ale`=0, `fl_we_n`=1, `fl_re_n`=1 and `fl_io_oe`=0. Reset also clears read mode.
- R10: A command, address or data-write cycle clears read mode. A data-port read when read mode is off makes no strobe and returns zero in bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Read target: 0 = data port, 1 = status |
| bus_wdata | input | 32 | Write word: bit 31 chip enable, 30:28 opcode, 23:16 byte |
| bus_rdata | output | 32 | Read word: 23:16 flash byte, bit 15 busy |
| bus_ack | output | 1 | One-cycle access completion |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_we_n | output | 1 | Write enable, active low |
| fl_re_n | output | 1 | Read enable, active low |
| fl_io_out | output | 8 | Byte driven to the flash I/O bus |
| fl_io_oe | output | 1 | Drive enable for the flash I/O bus |
| fl_io_in | input | 8 | Byte read from the flash I/O bus |
| fl_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The bench mixes cycle opcodes with the ignored opcodes 4 to 7. A decoder that took fewer than three opcode bits would turn an idle marker into a spurious write pulse. A decoder that let such markers clear read mode would lose the next data-port read.

It measures the write-enable and read-enable low times and the hold window in clocks. A counter off by one, or data released on the rising edge, shows up there.

It also covers four more cases:
- Repeated reads after one arm write, which must return successive bytes.
- A data-port read without arming, or after a reset taken while armed, which must make no strobe.
- Chip enable dropping when bit 31 is clear.
- The busy bit following the pin through the synchronizer.

// File: rtl/nand_bridge.sv
module nand_bridge #(
  parameter int WE_LOW = 3,
  parameter int HOLD   = 2,
  parameter int RE_LOW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ack,
  output logic        fl_ce_n,
  output logic        fl_cle,
  output logic        fl_ale,
  output logic        fl_we_n,
  output logic        fl_re_n,
  output logic [7:0]  fl_io_out,
  output logic        fl_io_oe,
  input  logic [7:0]  fl_io_in,
  input  logic        fl_rb_n
);
  localparam int MAXC = (WE_LOW > HOLD) ? ((WE_LOW > RE_LOW) ? WE_LOW : RE_LOW)
                                        : ((HOLD > RE_LOW) ? HOLD : RE_LOW);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WE_LD = CW'(WE_LOW - 1);
  localparam logic [CW-1:0] HD_LD = CW'(HOLD - 1);
  localparam logic [CW-1:0] RE_LD = CW'(RE_LOW - 1);

  typedef enum logic [1:0] {S_IDLE, S_WLOW, S_WHOLD, S_RLOW} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    rb_sync;
  logic          ce, armed;

  wire [2:0] op   = bus_wdata[30:28];
  wire       busy = ~rb_sync[1];
  wire       take = bus_req && !bus_ack && st == S_IDLE;
  wire       unused_bits = ^{bus_wdata[27:24], bus_wdata[15:0]};

  assign fl_ce_n = ~ce;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rb_sync <= 2'b11;
    else        rb_sync <= {rb_sync[0], fl_rb_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ce <= 1'b0; armed <= 1'b0;
      fl_cle <= 1'b0; fl_ale <= 1'b0; fl_we_n <= 1'b1; fl_re_n <= 1'b1;
      fl_io_out <= 8'h00; fl_io_oe <= 1'b0; bus_ack <= 1'b0; bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      case (st)
        S_IDLE:
          if (take) begin
            if (bus_we) begin
              ce <= bus_wdata[31];
              case (op)
                3'd0, 3'd1, 3'd3: begin
                  fl_io_out <= bus_wdata[23:16];
                  fl_cle    <= (op == 3'd0);
                  fl_ale    <= (op == 3'd1);
                  fl_io_oe  <= 1'b1;
                  fl_we_n   <= 1'b0;
                  armed     <= 1'b0;
                  cnt       <= WE_LD;
                  st        <= S_WLOW;
                end
                3'd2: begin
                  armed   <= 1'b1;
                  bus_ack <= 1'b1;
                end
                default: bus_ack <= 1'b1;
              endcase
            end else if (!bus_addr && armed) begin
              fl_re_n <= 1'b0;
              cnt     <= RE_LD;
              st      <= S_RLOW;
            end else begin
              bus_rdata <= {16'h0000, busy, 15'h0000};
              bus_ack   <= 1'b1;
            end
          end
        S_WLOW:
          if (cnt == '0) begin
            fl_we_n <= 1'b1;
            cnt     <= HD_LD;
            st      <= S_WHOLD;
          end else cnt <= cnt - 1'b1;
        S_WHOLD:
          if (cnt == '0) begin
            fl_io_oe <= 1'b0;
            fl_cle   <= 1'b0;
            fl_ale   <= 1'b0;
            bus_ack  <= 1'b1;
            st       <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        S_RLOW:
          if (cnt == '0) begin
            fl_re_n   <= 1'b1;
            bus_rdata <= {8'h00, fl_io_in, busy, 15'h0000};
            bus_ack   <= 1'b1;
            st        <= S_IDLE;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nand_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fl_cle,
  input logic       fl_ale,
  input logic       fl_we_n,
  input logic       fl_re_n,
  input logic       fl_io_oe,
  input logic [7:0] fl_io_out,
  input logic       bus_ack
);
  assert_cle_ale_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_cle && fl_ale));
  assert_drive_during_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_io_oe);
  assert_io_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_io_oe && $past(fl_io_oe)) |-> $stable(fl_io_out));
  assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_re_n |-> !fl_io_oe);
  assert_ack_after_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> (fl_we_n && fl_re_n && !fl_io_oe));
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_re_n));
endmodule

bind nand_bridge nand_bridge_chk chk (
  .clk(clk), .rst_n(rst_n), .fl_cle(fl_cle), .fl_ale(fl_ale),
  .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_io_oe(fl_io_oe),
  .fl_io_out(fl_io_out), .bus_ack(bus_ack)
);

// File: tb/nand_bridge_test.sv
module nand_bridge_test;
  localparam int WE_LOW = 3, HOLD = 2, RE_LOW = 4;
  localparam int NV = 7;
  localparam logic [31:0] WV [NV] = '{32'h8090_0000, 32'h9012_0000, 32'hB05A_0000,
                                      32'hD0FF_0000, 32'h30C3_0000, 32'hF0AA_0000,
                                      32'h0000_0000};
  localparam logic [10:0] EXP [NV] = '{{3'b110, 8'h90}, {3'b101, 8'h12}, {3'b100, 8'h5A},
                                       {3'b000, 8'h00}, {3'b100, 8'hC3}, {3'b000, 8'h00},
                                       {3'b110, 8'h00}};

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_addr = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack, fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_io_oe;
  logic [7:0] fl_io_out;
  logic [7:0] rd_val = 8'hA0;
  logic fl_rb_n = 1;
  int checks = 0, fails = 0;
  int wcount = 0, rcount = 0, we_run = 0, hold_run = 0, re_run = 0;
  int last_we = 0, last_hold = 0, last_re = 0;
  logic l_cle, l_ale, l_oe, prev_we = 1, prev_re = 1;
  logic [7:0] l_byte;

  always #2 clk = ~clk;

  nand_bridge #(.WE_LOW(WE_LOW), .HOLD(HOLD), .RE_LOW(RE_LOW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
    .fl_re_n(fl_re_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
    .fl_io_in(rd_val), .fl_rb_n(fl_rb_n));

  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n) begin
      we_run++;
      l_cle = fl_cle; l_ale = fl_ale; l_byte = fl_io_out; l_oe = fl_io_oe;
    end else if (we_run != 0) begin
      last_we = we_run; we_run = 0;
    end
    if (fl_we_n && !prev_we) wcount++;
    if (fl_we_n && fl_io_oe) hold_run++;
    else if (hold_run != 0) begin last_hold = hold_run; hold_run = 0; end
    if (!fl_re_n) re_run++;
    else if (re_run != 0) begin last_re = re_run; re_run = 0; end
    if (fl_re_n && !prev_re) begin rcount++; rd_val = rd_val + 8'h01; end
    prev_we = fl_we_n; prev_re = fl_re_n;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = addr; bus_wdata = wd; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!bus_ack);
    rd = bus_rdata; bus_req = 0;
  endtask

  task automatic check_reset_pins(input string req);
    check({fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_io_oe} == 6'b100110, req,
          {26'h0, fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_io_oe}, 32'h26);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int cyc, w0, r0;
    repeat (3) @(negedge clk);
    check_reset_pins("R9 reset pins");
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      w0 = wcount;
      access(1, 0, WV[i], rd, cyc);
      @(negedge clk);
      check(wcount - w0 == int'(EXP[i][10]), "R7 R3 cycle count", wcount - w0, EXP[i][10]);
      if (EXP[i][10]) begin
        check({l_cle, l_ale} == EXP[i][9:8], "R1 latch lines", {l_cle, l_ale}, EXP[i][9:8]);
        check(l_byte == EXP[i][7:0] && l_oe, "R3 byte", l_byte, EXP[i][7:0]);
        check(last_we == WE_LOW, "R4 we low width", last_we, WE_LOW);
        check(last_hold == HOLD, "R4 hold width", last_hold, HOLD);
        check(cyc == WE_LOW + HOLD + 1, "R8 ack latency", cyc, WE_LOW + HOLD + 1);
      end
      check(fl_ce_n == ~WV[i][31], "R2 chip enable", fl_ce_n, ~WV[i][31]);
      check(!fl_io_oe, "R4 bus released", fl_io_oe, 0);
    end

    w0 = wcount;
    for (int i = 0; i < 4; i++) access(1, 0, 32'hB000_0000 | (32'(8'h31 + i) << 16), rd, cyc);
    @(negedge clk);
    check(wcount - w0 == 4, "R3 burst count", wcount - w0, 4);
    check(l_byte == 8'h34, "R3 burst last byte", l_byte, 8'h34);

    access(1, 0, 32'hA000_0000, rd, cyc);
    for (int i = 0; i < 3; i++) begin
      r0 = rcount;
      access(0, 0, 0, rd, cyc);
      @(negedge clk);
      check(rd[23:16] == 8'(8'hA0 + i), "R5 read byte", rd[23:16], 8'hA0 + i);
      check(rcount - r0 == 1 && last_re == RE_LOW, "R5 strobe width", last_re, RE_LOW);
    end
    r0 = rcount;
    access(0, 1, 0, rd, cyc);
    check(rcount == r0 && rd[23:16] == 0, "R6 status no strobe", rcount - r0, 0);
    access(1, 0, 32'hE000_0000, rd, cyc);
    access(0, 0, 0, rd, cyc);
    check(rd[23:16] == 8'hA3, "R7 ignored op keeps read mode", rd[23:16], 8'hA3);
    access(1, 0, 32'h80FF_0000, rd, cyc);
    r0 = rcount;
    access(0, 0, 0, rd, cyc);
    check(rcount == r0 && rd[23:16] == 0, "R10 cycle clears read mode", rcount - r0, 0);

    fl_rb_n = 0; repeat (4) @(negedge clk);
    access(0, 1, 0, rd, cyc);
    check(rd[15] == 1'b1, "R6 busy set", rd[15], 1);
    fl_rb_n = 1; repeat (4) @(negedge clk);
    access(0, 1, 0, rd, cyc);
    check(rd[15] == 1'b0, "R6 busy clear", rd[15], 0);

    access(1, 0, 32'hA000_0000, rd, cyc);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    check_reset_pins("R9 reset after arm");
    rst_n = 1;
    r0 = rcount;
    access(0, 0, 0, rd, cyc);
    @(negedge clk);
    check(rcount == r0 && rd[23:16] == 0, "R9 reset clears read mode", rcount - r0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule